// File: doc/BRIEF.md
# Operate-Instruction Execute Unit with Sign Flags

This block is the execute stage for the three register-to-register operate instructions of a 16-bit processor: addition, bitwise AND and bitwise complement. It takes the 16-bit instruction word and the two values read from the register file. It decodes the word and sends the two source register indices back to the register file. It then forms the second operand, either from the second register value or from a sign-extended 5-bit immediate. It produces the 16-bit result, the destination register index and a write enable.

A registered three-bit sign code records whether the last executed result was negative, zero or positive. A branch unit reads this code. The result path is combinational. The sign code changes only on a clock edge at which an execute strobe is high and the instruction is a well-formed operate instruction. Register storage, fetch and memory access live in neighbouring blocks.

Top module: `alu_cc_exec`

## Requirements
- R1: Opcode 0001 (bits 15:12) is addition. `result` equals `src_a` plus the second operand modulo 2^16. Nothing indicates overflow.
- R2: Bit 5 chooses the second operand. When bit 5 is 0, the second operand is `src_b`. When bit 5 is 1, it is bits 4:0 sign-extended to 16 bits, so bit 4 is copied into bits 15:5.
- R3: Opcode 0101 is bitwise AND of `src_a` with the second operand.
- R4: Opcode 1001 is complement. `result` is the bitwise inverse of `src_a`, and the instruction is well formed only when bits 5:0 are all ones.
- R5: The index outputs are decoded from fixed fields. `dst_idx` is bits 11:9, `sr1_idx` is bits 8:6 and `sr2_idx` is bits 2:0.
- R6: `wr_en` is high only when `exec_en` is high and the instruction is a well-formed operate instruction.
- R7: On a clock edge with `exec_en` high and a well-formed instruction, `cc` is loaded from that cycle's result. The code is one-hot: `cc[2]` marks negative (bit 15 set), `cc[1]` marks zero and `cc[0]` marks positive. The new value is visible after that edge.
- R8: A synchronous active-high `rst` sets `cc` to 3'b010, the zero code.
- R9: `cc` keeps its value on every edge where `exec_en` is low or the instruction is not well formed.
- R10: Some instructions are not well formed: any other opcode, the register form of addition or AND with bits 4:3 not equal to 00, and complement with bits 5:0 not all ones. Such an instruction drives `result` to zero and `wr_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe for the presented instruction |
| instr | input | 16 | Instruction word |
| src_a | input | 16 | Value of register sr1_idx |
| src_b | input | 16 | Value of register sr2_idx |
| sr1_idx | output | 3 | First source register index |
| sr2_idx | output | 3 | Second source register index |
| result | output | 16 | Operation result |
| dst_idx | output | 3 | Destination register index |
| wr_en | output | 1 | Register write enable |
| cc | output | 3 | Registered sign code {negative, zero, positive} |

## Verification
Assertions check three things on every cycle. The sign code stays one-hot. It follows the sign of the previous cycle's result after a strobed well-formed instruction, and it holds otherwise. A malformed instruction never raises the write enable.

The bench has to show the arithmetic itself. It sweeps boundary operand values through both operand forms and all 32 immediates, and it uses an arithmetic model to check carries that wrap, sign extension and complement. It also walks all sixteen opcodes and the malformed encodings to confirm the absence of writes and flag changes.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = 3;
    localparam int IMM_W  = 5;
    localparam int OPC_W  = 4;
    localparam int CC_W   = 3;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

    localparam logic [CC_W-1:0] CC_NEG  = 3'b100;
    localparam logic [CC_W-1:0] CC_ZERO = 3'b010;
    localparam logic [CC_W-1:0] CC_POS  = 3'b001;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_ADD  = 2'd1,
        OPK_AND  = 2'd2,
        OPK_NOT  = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e               kind;
        logic                   valid;
        logic                   use_imm;
        logic [IDX_W-1:0]       dst;
        logic [IDX_W-1:0]       sr1;
        logic [IDX_W-1:0]       sr2;
        logic [IMM_W-1:0]       imm;
    } dec_t;

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [CC_W-1:0] sign_code(input logic [WORD_W-1:0] v);
        if (v[WORD_W-1])
            return CC_NEG;
        else if (v == '0)
            return CC_ZERO;
        else
            return CC_POS;
    endfunction

endpackage

// File: rtl/alu_cc_decode.sv
module alu_cc_decode
    import alu_cc_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output dec_t              dec
);
    localparam int OPC_LSB = WORD_W - OPC_W;
    localparam int DST_LSB = OPC_LSB - IDX_W;
    localparam int SR1_LSB = DST_LSB - IDX_W;
    localparam int SEL_BIT = IMM_W;

    logic [OPC_W-1:0] opc;
    logic             mode_bit;
    logic [1:0]       pad_bits;
    logic [5:0]       low6;

    always_comb begin
        opc      = instr[WORD_W-1:OPC_LSB];
        mode_bit = instr[SEL_BIT];
        pad_bits = instr[IMM_W-1:IDX_W];
        low6     = instr[5:0];

        dec         = '0;
        dec.dst     = instr[DST_LSB+IDX_W-1:DST_LSB];
        dec.sr1     = instr[SR1_LSB+IDX_W-1:SR1_LSB];
        dec.sr2     = instr[IDX_W-1:0];
        dec.imm     = instr[IMM_W-1:0];
        dec.use_imm = mode_bit;
        dec.kind    = OPK_NONE;
        dec.valid   = 1'b0;

        unique case (opc)
            OPC_ADD: begin
                dec.kind  = OPK_ADD;
                dec.valid = mode_bit || (pad_bits == 2'b00);
            end
            OPC_AND: begin
                dec.kind  = OPK_AND;
                dec.valid = mode_bit || (pad_bits == 2'b00);
            end
            OPC_NOT: begin
                dec.kind  = OPK_NOT;
                dec.valid = (low6 == 6'b111111);
            end
            default: begin
                dec.kind  = OPK_NONE;
                dec.valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core
    import alu_cc_pkg::*;
(
    input  dec_t              dec,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic [WORD_W-1:0] result
);
    logic [WORD_W-1:0] opnd_b;
    logic [WORD_W-1:0] sum;

    always_comb begin
        opnd_b = dec.use_imm ? sext_imm(dec.imm) : src_b;
        sum    = src_a + opnd_b;
        result = '0;
        if (dec.valid) begin
            unique case (dec.kind)
                OPK_ADD:  result = sum;
                OPK_AND:  result = src_a & opnd_b;
                OPK_NOT:  result = ~src_a;
                default:  result = '0;
            endcase
        end
    end

endmodule

// File: rtl/alu_cc_flags.sv
module alu_cc_flags
    import alu_cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] value,
    output logic [CC_W-1:0]   cc
);
    logic [CC_W-1:0] cc_q;

    always_ff @(posedge clk) begin
        if (rst)
            cc_q <= CC_ZERO;
        else if (load)
            cc_q <= sign_code(value);
    end

    assign cc = cc_q;

    AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(cc_q) == 1); // R7

    AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cc_q)); // R9

    AST_CC_NEG_TRACK: assert property (@(posedge clk) disable iff (rst)
        (load && value[WORD_W-1]) |=> cc_q[2]); // R7

    AST_CC_ZERO_TRACK: assert property (@(posedge clk) disable iff (rst)
        (load && value == '0) |=> cc_q[1]); // R7

endmodule

// File: rtl/alu_cc_exec.sv
module alu_cc_exec
    import alu_cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [15:0]       instr,
    input  logic [15:0]       src_a,
    input  logic [15:0]       src_b,
    output logic [2:0]        sr1_idx,
    output logic [2:0]        sr2_idx,
    output logic [15:0]       result,
    output logic [2:0]        dst_idx,
    output logic              wr_en,
    output logic [2:0]        cc
);
    dec_t dec;
    logic commit;

    alu_cc_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    alu_cc_core u_core (
        .dec    (dec),
        .src_a  (src_a),
        .src_b  (src_b),
        .result (result)
    );

    assign commit  = exec_en && dec.valid;
    assign wr_en   = commit;
    assign dst_idx = dec.dst;
    assign sr1_idx = dec.sr1;
    assign sr2_idx = dec.sr2;

    alu_cc_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .load  (commit),
        .value (result),
        .cc    (cc)
    );

    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !dec.valid |-> (!wr_en && result == '0)); // R10

    AST_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !exec_en |-> !wr_en); // R6

    AST_CC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cc == sign_code($past(result))); // R7

endmodule

// File: tb/alu_cc_exec_tb.sv
module alu_cc_exec_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        exec_en;
    logic [15:0] instr, src_a, src_b;
    logic [2:0]  sr1_idx, sr2_idx, dst_idx, cc;
    logic [15:0] result;
    logic        wr_en;

    int n_tests = 0;
    int n_fail  = 0;
    logic [2:0] exp_cc;

    always #2 clk = ~clk;

    alu_cc_exec u_dut (
        .clk(clk), .rst(rst), .exec_en(exec_en), .instr(instr),
        .src_a(src_a), .src_b(src_b), .sr1_idx(sr1_idx), .sr2_idx(sr2_idx),
        .result(result), .dst_idx(dst_idx), .wr_en(wr_en), .cc(cc)
    );

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [2:0] model_cc(input logic [15:0] v);
        if (v >= 16'h8000) return 3'b100;
        if (v == 16'd0)    return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic [15:0] vsel(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h1234;
            6: return 16'h00FF;
            default: return 16'hFF00;
        endcase
    endfunction

    // Presents one instruction with the strobe, checks the combinational
    // outputs, then the sign code after the edge.
    task automatic run(input logic [15:0] ins, input logic [15:0] a, input logic [15:0] b,
                       input logic strobe, input logic ok, input logic [15:0] exp_res,
                       input string tag);
        @(negedge clk);
        instr = ins; src_a = a; src_b = b; exec_en = strobe;
        #1;
        check({tag, " R6 wr_en"}, {15'd0, wr_en}, {15'd0, strobe & ok});
        check({tag, " result"}, result, ok ? exp_res : 16'h0000);
        check({tag, " R5 dst"}, {13'd0, dst_idx}, {13'd0, ins[11:9]});
        check({tag, " R5 sr1"}, {13'd0, sr1_idx}, {13'd0, ins[8:6]});
        check({tag, " R5 sr2"}, {13'd0, sr2_idx}, {13'd0, ins[2:0]});
        if (strobe && ok) exp_cc = model_cc(exp_res);
        @(posedge clk);
        #1;
        check({tag, " R7 R9 cc"}, {13'd0, cc}, {13'd0, exp_cc});
        exec_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; exec_en = 1'b0; instr = '0; src_a = '0; src_b = '0;
        exp_cc = 3'b010;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R8 reset cc", {13'd0, cc}, 16'h0002);
        check("R6 idle wr_en", {15'd0, wr_en}, 16'h0000);

        // R1 and R3, register form
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [15:0] a, b, ins;
                a = vsel(i); b = vsel(j);
                ins = {4'b0001, 3'(i), 3'(j), 1'b0, 2'b00, 3'(i + j)};
                run(ins, a, b, 1'b1, 1'b1, 16'((32'(a) + 32'(b)) % 65536), "R1 add reg");
                ins = {4'b0101, 3'(j), 3'(i), 1'b0, 2'b00, 3'(j)};
                run(ins, a, b, 1'b1, 1'b1, a & b, "R3 and reg");
            end
        end

        // R2 immediate form: every immediate against every boundary value
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 32; k++) begin
                logic [15:0] a, sx, ins;
                a  = vsel(i);
                sx = (k >= 16) ? 16'(k - 32) : 16'(k);
                ins = {4'b0001, 3'(k), 3'(i), 1'b1, 5'(k)};
                run(ins, a, 16'hDEAD, 1'b1, 1'b1, a + sx, "R2 add imm");
                ins = {4'b0101, 3'(i), 3'(k), 1'b1, 5'(k)};
                run(ins, a, 16'hBEEF, 1'b1, 1'b1, a & sx, "R2 and imm");
            end
        end

        // R4 complement
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a;
            a = vsel(i);
            run({4'b1001, 3'(i), 3'(7 - i), 6'b111111}, a, 16'h5555, 1'b1, 1'b1,
                16'hFFFF - a, "R4 not");
        end

        // R9 strobe low: load a positive code first, then an idle negative result
        run({4'b0001, 3'd1, 3'd2, 1'b1, 5'd1}, 16'h0001, 16'h0, 1'b1, 1'b1, 16'h0002, "R9 setup");
        run({4'b0001, 3'd1, 3'd2, 1'b0, 2'b00, 3'd3}, 16'h8000, 16'h0001, 1'b0, 1'b1,
            16'h8001, "R9 idle");

        // R10 every other opcode is ignored
        for (int op = 0; op < 16; op++) begin
            if (op != 1 && op != 5 && op != 9)
                run({4'(op), 12'hA7F}, 16'h8000, 16'h8000, 1'b1, 1'b0, 16'h0, "R10 opcode");
        end
        // R10 malformed encodings
        for (int p = 1; p < 4; p++) begin
            run({4'b0001, 3'd2, 3'd3, 1'b0, 2'(p), 3'd4}, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0,
                16'h0, "R10 add pad");
            run({4'b0101, 3'd2, 3'd3, 1'b0, 2'(p), 3'd4}, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0,
                16'h0, "R10 and pad");
        end
        for (int b = 0; b < 6; b++) begin
            logic [5:0] low;
            low = 6'b111111 ^ (6'd1 << b);
            run({4'b1001, 3'd5, 3'd6, low}, 16'h0000, 16'h0, 1'b1, 1'b0, 16'h0, "R10 not low");
        end

        // R8 reset mid-run returns to the zero code
        run({4'b1001, 3'd0, 3'd0, 6'b111111}, 16'h0000, 16'h0, 1'b1, 1'b1, 16'hFFFF, "R8 pre");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8 reset cc again", {13'd0, cc}, 16'h0002);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule